// File: doc/BRIEF.md
# Microprogram Halt and Interlock Control

This block sits beside the sequencer of a vector coprocessor. Every issued upper instruction brings five control flags, and the block decides from them whether the microprogram keeps running. It also raises the debug and trap interrupts toward the host, releases interlocked host register writes, and loads the immediate register. The host starts or resumes the unit with a continue pulse. It clears latched interrupts with write-one-to-clear pulses. It posts interlocked transfer requests, and each one waits until the microprogram issues an instruction marked for rendezvous.

The run state is a three-state machine:
- STOP is the reset state. The unit is halted.
- RUN means instructions issue.
- SLOT means a stop flag has been seen and one more instruction, the delay slot, will issue before the halt.

The transitions are:
- STOP→RUN on a continue pulse.
- RUN→SLOT on an issued instruction with the end flag set.
- RUN→STOP on an issued instruction whose debug or trap flag is set while the matching enable is set.
- SLOT→STOP on the next issued instruction.

The flag vector `ctl_flags` uses this bit order: bit 0 = immediate-load, bit 1 = end, bit 2 = rendezvous, bit 3 = debug, bit 4 = trap. The bit order matters because the issuing decoder drives this vector.

Top module: `mpc_ctl`

## Requirements
- R1: After reset, `running`, `dbg_irq`, `trap_irq`, `xfer_ack` and `imm_load` are all 0, and no transfer is pending.
- R2: A `host_cont` pulse in STOP makes `running` 1 after the next clock edge.
- R3: An issued instruction with the end flag (bit 1) keeps `running` at 1. The next issued instruction (the delay slot) is still accepted, and `running` falls after it. An end flag on the delay-slot instruction has no further effect.
- R4: An issued instruction with the immediate-load flag (bit 0) gives a one-cycle `imm_load` pulse after its edge, and `imm_value` equals its `lower_word`. Without the flag, `imm_load` stays 0 and `imm_value` keeps its value.
- R5: An issued instruction with the debug flag (bit 3) while `dbg_en` is 1 stops the unit right after it and sets `dbg_irq`. While `dbg_en` is 0 the flag has no effect.
- R6: An issued instruction with the trap flag (bit 4) while `trap_en` is 1 stops the unit right after it and sets `trap_irq`. While `trap_en` is 0 the flag has no effect.
- R7: A `xfer_req` pulse becomes pending. The first issued instruction with the rendezvous flag (bit 2) in a later cycle gives a one-cycle `xfer_ack` pulse after its edge. A rendezvous instruction with nothing pending gives no pulse.
- R8: Up to PEND_DEPTH (default 2) requests are held and acknowledged one per rendezvous instruction, in order. A request that arrives while the store is full is dropped.
- R9: `dbg_irq` and `trap_irq` stay at 1 until `irq_clr[0]` or `irq_clr[1]` respectively is pulsed. A set and a clear in the same cycle leave the line at 1.
- R10: A `host_cont` pulse in RUN or SLOT is ignored. `issue_vld` in STOP has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction issues this cycle |
| ctl_flags | input | 5 | Upper-instruction control flags of the issuing instruction |
| lower_word | input | 32 | Paired lower instruction word |
| host_cont | input | 1 | Host continue pulse |
| xfer_req | input | 1 | Host interlocked transfer request pulse |
| dbg_en | input | 1 | Debug interrupt/stop enable |
| trap_en | input | 1 | Trap interrupt/stop enable |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 debug, bit 1 trap |
| running | output | 1 | 1 in RUN or SLOT |
| dbg_irq | output | 1 | Latched debug interrupt |
| trap_irq | output | 1 | Latched trap interrupt |
| xfer_ack | output | 1 | Interlocked transfer accepted strobe |
| imm_load | output | 1 | Immediate-register load strobe |
| imm_value | output | 32 | Value loaded into the immediate register |

## Verification
The hardest situation to reach is a full pending-request store meeting a third request, followed by a run of rendezvous instructions. The bench posts three requests while the unit runs without rendezvous flags. It then issues three rendezvous instructions and expects exactly two acknowledges. The delay slot is the other subtle case. The bench places an end flag on the delay-slot instruction and checks that the unit still stops after exactly one slot. It also checks that the unit restarts normally after a continue.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    localparam int FLAG_W  = 5;
    localparam int F_IMM   = 0;
    localparam int F_END   = 1;
    localparam int F_RDV   = 2;
    localparam int F_DBG   = 3;
    localparam int F_TRAP  = 4;
    localparam int IRQ_N   = 2;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_SLOT = 2'd2
    } run_state_e;
endpackage

// File: rtl/mpc_run_fsm.sv
module mpc_run_fsm
    import mpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_vld,
    input  logic flag_end,
    input  logic halt_dt,
    input  logic host_cont,
    output logic running,
    output logic issue_ok
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (host_cont) state_d = ST_RUN;
            ST_RUN: begin
                if (issue_vld) begin
                    if (halt_dt)       state_d = ST_STOP;
                    else if (flag_end) state_d = ST_SLOT;
                end
            end
            ST_SLOT: if (issue_vld) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    always_comb begin
        running  = (state_q != ST_STOP);
        issue_ok = issue_vld && (state_q != ST_STOP);
    end

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && host_cont) |=> (state_q == ST_RUN));
    a_r3_slot_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && issue_vld && flag_end && !halt_dt) |=> (state_q == ST_SLOT));
    a_r3_slot_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT && issue_vld) |=> (state_q == ST_STOP));
    a_r10_cont_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STOP && host_cont && !issue_vld) |=> $stable(state_q));
endmodule

// File: rtl/mpc_irq_latch.sv
module mpc_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign irq_o = q;

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i) |=> q);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
endmodule

// File: rtl/mpc_xfer_gate.sv
module mpc_xfer_gate #(
    parameter int PEND_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rdv_i,
    output logic ack_o
);
    localparam int CW = $clog2(PEND_DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(PEND_DEPTH);

    logic [CW-1:0] pend_q;
    logic          ack_q;
    logic          take, accept;

    always_comb begin
        take   = rdv_i && (pend_q != '0);
        accept = req_i && ((pend_q != DEPTH_C) || take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            pend_q <= pend_q + CW'(accept) - CW'(take);
            ack_q  <= take;
        end
    end

    assign ack_o = ack_q;

    a_r7_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> ($past(pend_q) != '0));
    a_r8_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= DEPTH_C);
    a_r7_no_rdv_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !rdv_i |=> !ack_q);
endmodule

// File: rtl/mpc_imm_reg.sv
module mpc_imm_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              strobe_o,
    output logic [WORD_W-1:0] value_o
);
    logic              stb_q;
    logic [WORD_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            val_q <= '0;
        end else begin
            stb_q <= load_i;
            if (load_i) val_q <= word_i;
        end
    end

    assign strobe_o = stb_q;
    assign value_o  = val_q;

    a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(val_q));
endmodule

// File: rtl/mpc_ctl.sv
module mpc_ctl
    import mpc_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PEND_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [4:0]        ctl_flags,
    input  logic [WORD_W-1:0] lower_word,
    input  logic              host_cont,
    input  logic              xfer_req,
    input  logic              dbg_en,
    input  logic              trap_en,
    input  logic [1:0]        irq_clr,
    output logic              running,
    output logic              dbg_irq,
    output logic              trap_irq,
    output logic              xfer_ack,
    output logic              imm_load,
    output logic [WORD_W-1:0] imm_value
);
    logic             issue_ok;
    logic [IRQ_N-1:0] irq_hit, irq_en_v, irq_flag_v, irq_q;
    logic             halt_dt;

    always_comb begin
        irq_en_v   = {trap_en, dbg_en};
        irq_flag_v = {ctl_flags[F_TRAP], ctl_flags[F_DBG]};
        irq_hit    = {IRQ_N{issue_ok}} & irq_en_v & irq_flag_v;
        halt_dt    = |irq_hit;
    end

    mpc_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_vld (issue_vld),
        .flag_end  (ctl_flags[F_END]),
        .halt_dt   (halt_dt),
        .host_cont (host_cont),
        .running   (running),
        .issue_ok  (issue_ok)
    );

    for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
        mpc_irq_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (irq_hit[g]),
            .clr_i (irq_clr[g]),
            .irq_o (irq_q[g])
        );
    end

    assign dbg_irq  = irq_q[0];
    assign trap_irq = irq_q[1];

    mpc_xfer_gate #(.PEND_DEPTH(PEND_DEPTH)) u_xfer (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (xfer_req),
        .rdv_i (issue_ok && ctl_flags[F_RDV]),
        .ack_o (xfer_ack)
    );

    mpc_imm_reg #(.WORD_W(WORD_W)) u_imm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (issue_ok && ctl_flags[F_IMM]),
        .word_i   (lower_word),
        .strobe_o (imm_load),
        .value_o  (imm_value)
    );

    a_r5_dbg_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_irq) |-> $past(dbg_en));
    a_r6_trap_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_irq) |-> $past(trap_en));
    a_r5_dt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        halt_dt |=> !running);
    a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !xfer_req) |=> !xfer_ack && !imm_load);
endmodule

// File: tb/mpc_ctl_test.sv
module mpc_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [4:0]  ctl_flags = '0;
    logic [31:0] lower_word = '0;
    logic        host_cont = 1'b0;
    logic        xfer_req = 1'b0;
    logic        dbg_en = 1'b0;
    logic        trap_en = 1'b0;
    logic [1:0]  irq_clr = '0;
    logic        running, dbg_irq, trap_irq, xfer_ack, imm_load;
    logic [31:0] imm_value;

    int total = 0;
    int bad = 0;

    localparam logic [4:0] FI = 5'b00001, FE = 5'b00010, FM = 5'b00100,
                           FD = 5'b01000, FT = 5'b10000;

    always #2.5 clk = ~clk;

    mpc_ctl uut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .ctl_flags(ctl_flags),
        .lower_word(lower_word), .host_cont(host_cont), .xfer_req(xfer_req),
        .dbg_en(dbg_en), .trap_en(trap_en), .irq_clr(irq_clr),
        .running(running), .dbg_irq(dbg_irq), .trap_irq(trap_irq),
        .xfer_ack(xfer_ack), .imm_load(imm_load), .imm_value(imm_value)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic iv, input logic [4:0] f, input logic [31:0] w,
                       input logic cont, input logic req, input logic [1:0] clr);
        @(negedge clk);
        issue_vld = iv; ctl_flags = f; lower_word = w;
        host_cont = cont; xfer_req = req; irq_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, '0, '0, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic start();
        cyc(1'b0, '0, '0, 1'b1, 1'b0, 2'b00);
    endtask

    task automatic t_reset();
        chk("R1 running", running, 0);
        chk("R1 dbg_irq", dbg_irq, 0);
        chk("R1 trap_irq", trap_irq, 0);
        chk("R1 xfer_ack", xfer_ack, 0);
        chk("R1 imm_load", imm_load, 0);
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R10 issue while stopped", running, 0);
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R1 nothing pending", xfer_ack, 0);
    endtask

    task automatic t_start();
        start();
        chk("R2 continue starts", running, 1);
        cyc(1'b0, '0, '0, 1'b1, 1'b0, 2'b00);
        chk("R10 continue while running", running, 1);
    endtask

    task automatic t_end_slot();
        cyc(1'b1, FE, '0, 1'b0, 1'b0, 2'b00);
        chk("R3 still running after E", running, 1);
        cyc(1'b0, '0, '0, 1'b1, 1'b0, 2'b00);
        chk("R10 continue in slot", running, 1);
        cyc(1'b1, FE | FI, 32'h4049_0FD0, 1'b0, 1'b0, 2'b00);
        chk("R3 stop after slot", running, 0);
        chk("R3 slot instruction accepted", imm_load, 1);
        idle();
        chk("R3 stays stopped", running, 0);
        start();
        chk("R3 restart", running, 1);
        cyc(1'b1, '0, '0, 1'b0, 1'b0, 2'b00);
        chk("R3 no stale slot", running, 1);
    endtask

    task automatic t_imm();
        cyc(1'b1, FI, 32'h3F80_0000, 1'b0, 1'b0, 2'b00);
        chk("R4 strobe", imm_load, 1);
        chk("R4 value", imm_value, 32'h3F80_0000);
        cyc(1'b1, '0, 32'hDEAD_BEEF, 1'b0, 1'b0, 2'b00);
        chk("R4 strobe one cycle", imm_load, 0);
        chk("R4 value kept", imm_value, 32'h3F80_0000);
    endtask

    task automatic t_dbg();
        dbg_en = 1'b0;
        cyc(1'b1, FD, '0, 1'b0, 1'b0, 2'b00);
        chk("R5 disabled no stop", running, 1);
        chk("R5 disabled no irq", dbg_irq, 0);
        dbg_en = 1'b1;
        cyc(1'b1, FD, '0, 1'b0, 1'b0, 2'b00);
        chk("R5 stop", running, 0);
        chk("R5 irq", dbg_irq, 1);
        idle(); idle();
        chk("R9 dbg held", dbg_irq, 1);
        start();
        cyc(1'b1, FD, '0, 1'b0, 1'b0, 2'b01);
        chk("R9 set wins over clear", dbg_irq, 1);
        cyc(1'b0, '0, '0, 1'b0, 1'b0, 2'b01);
        chk("R9 dbg cleared", dbg_irq, 0);
        dbg_en = 1'b0;
    endtask

    task automatic t_trap();
        start();
        trap_en = 1'b0;
        cyc(1'b1, FT, '0, 1'b0, 1'b0, 2'b00);
        chk("R6 disabled no stop", running, 1);
        chk("R6 disabled no irq", trap_irq, 0);
        trap_en = 1'b1;
        cyc(1'b1, FT, '0, 1'b0, 1'b0, 2'b00);
        chk("R6 stop", running, 0);
        chk("R6 irq", trap_irq, 1);
        cyc(1'b0, '0, '0, 1'b0, 1'b0, 2'b01);
        chk("R9 dbg clear leaves trap", trap_irq, 1);
        cyc(1'b0, '0, '0, 1'b0, 1'b0, 2'b10);
        chk("R9 trap cleared", trap_irq, 0);
        trap_en = 1'b0;
    endtask

    task automatic t_xfer();
        start();
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R7 no pending no ack", xfer_ack, 0);
        cyc(1'b1, FM, '0, 1'b0, 1'b1, 2'b00);
        chk("R7 same-cycle request waits", xfer_ack, 0);
        cyc(1'b1, '0, '0, 1'b0, 1'b0, 2'b00);
        chk("R7 held without M", xfer_ack, 0);
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R7 ack on M", xfer_ack, 1);
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R7 single ack", xfer_ack, 0);
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 2'b00);
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 2'b00);
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 2'b00);
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R8 first of queue", xfer_ack, 1);
        cyc(1'b1, '0, '0, 1'b0, 1'b0, 2'b00);
        chk("R8 gap", xfer_ack, 0);
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R8 second of queue", xfer_ack, 1);
        cyc(1'b1, FM, '0, 1'b0, 1'b0, 2'b00);
        chk("R8 overflow dropped", xfer_ack, 0);
    endtask

    initial begin
        bit timed_out = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        fork
            begin
                t_reset();
                t_start();
                t_end_slot();
                t_imm();
                t_dbg();
                t_trap();
                t_xfer();
            end
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule